// File: doc/BRIEF.md
# Board Local Reset Generator with Software Watchdog

This block merges every reason a board has to restart into one active-low local reset. The reasons are power-on, an external system reset line, a debounced front-panel button, a self-clearing software reset bit, a bus grant-in line that counts only when a strap marks the board as system controller, and the expiry of a software watchdog. Any reason that fires holds the local reset low for a fixed minimum number of clocks. The output is released synchronously to the clock.

The watchdog counts whole milliseconds from a prescaler that is derived from the clock frequency parameter, so a simulation can run with a scaled-down clock. Software keeps the board alive by driving its clear bit from 0 to 1 inside each window. Holding the bit high does not restart the window. The watchdog also restarts from zero when power-on reset is released. An enable bit stops the watchdog completely.

Top module: `brg_local_reset`

## Requirements
- R1: While `rst` (power-on, synchronous, active high) is high, `lrst_n_o` is low and `sw_rst_o` is 0. After the last clock in which `rst` was high, `lrst_n_o` stays low for HOLD_CLKS-1 further clocks and then goes high.
- R2: A low level on `sys_rst_n_i` drives `lrst_n_o` low.
- R3: A high level on `button_i` drives `lrst_n_o` low.
- R4: A low level on `bus_grant_n_i` drives `lrst_n_o` low only when `sys_ctrl_i` is 1. When `sys_ctrl_i` is 0, the grant line has no effect.
- R5: A one-clock pulse on `sw_rst_wr_i` sets the software reset bit (`sw_rst_o`) on the next clock edge. The bit then drives `lrst_n_o` low one clock later. The bit clears itself on the first clock edge that sees `lrst_n_o` low. Writes made while `lrst_n_o` is low are ignored.
- R6: `sys_rst_n_i`, `button_i` and `bus_grant_n_i` pass through two synchroniser flops, so `lrst_n_o` falls on the third clock edge after the input changes. A reason that is active for one clock holds `lrst_n_o` low for exactly HOLD_CLKS clocks.
- R7: With the watchdog enabled and never cleared, `lrst_n_o` falls exactly WD_MS*(CLK_HZ/1000)+1 clock edges after the edge on which the watchdog restarted.
- R8: The watchdog restarts only on a clock edge that sees `wd_clr_i` at 1 after it was 0 on the previous edge, or on release of `rst`. A steady high level on `wd_clr_i` does not restart it.
- R9: While `wd_en_i` is 0, the watchdog never expires and its count is held at zero. Enabling it starts a full window.
- R10: A restart that falls in the same clock as the final tick of a window wins. No expiry is produced, and a new full window begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| sys_rst_n_i | input | 1 | External system reset, asynchronous, active low |
| button_i | input | 1 | Debounced front-panel reset button, asynchronous, active high |
| bus_grant_n_i | input | 1 | Bus grant-in line, asynchronous, active low |
| sys_ctrl_i | input | 1 | Strap: 1 when the board is system controller |
| sw_rst_wr_i | input | 1 | One-clock write pulse that sets the software reset bit |
| wd_en_i | input | 1 | Watchdog enable |
| wd_clr_i | input | 1 | Watchdog clear bit; its 0-to-1 edge restarts the window |
| lrst_n_o | output | 1 | Local reset, active low, registered |
| sw_rst_o | output | 1 | Current value of the software reset bit |

## Verification
The collision that matters is a watchdog restart landing in the same clock as the terminal millisecond tick that would otherwise expire the window. The bench counts clocks from a known restart edge and raises the clear bit so that its rising edge is sampled exactly on the expiry edge. It then judges the result: `lrst_n_o` must stay high through that edge, and a second expiry must arrive one full window later with the clear bit held high. A second overlap comes from a software reset write landing while local reset is already low; that write must leave `sw_rst_o` at 0.

// File: rtl/brg_pkg.sv
package brg_pkg;

  // synchronised asynchronous reset reasons, all active high
  typedef struct packed {
    logic sys;
    logic btn;
    logic gnt;
  } brg_src_t;

  function automatic int unsigned brg_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/brg_sync.sv
module brg_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end

endmodule

// File: rtl/brg_wdog.sv
module brg_wdog #(
  parameter int unsigned CLK_PER_MS = 125000,
  parameter int unsigned WD_MS      = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic clr_i,
  output logic expire_o
);
  import brg_pkg::*;

  localparam int unsigned PRE_W = brg_bits(CLK_PER_MS);
  localparam int unsigned MS_W  = brg_bits(WD_MS);
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLK_PER_MS - 1);
  localparam logic [MS_W-1:0]  MS_MAX  = MS_W'(WD_MS - 1);

  logic             clr_q;
  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;
  logic             kick, tick;

  assign kick = clr_i & ~clr_q;
  assign tick = en_i & (pre_q == PRE_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_q    <= clr_i;
      pre_q    <= '0;
      ms_q     <= '0;
      expire_o <= 1'b0;
    end else begin
      clr_q    <= clr_i;
      expire_o <= 1'b0;
      if (kick || !en_i) begin
        pre_q <= '0;
        ms_q  <= '0;
      end else if (tick) begin
        pre_q <= '0;
        if (ms_q == MS_MAX) begin
          ms_q     <= '0;
          expire_o <= 1'b1;
        end else begin
          ms_q <= ms_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R10: a restart edge never yields an expiry in the following cycle
  a_r10_kick_wins: assert property (@(posedge clk) disable iff (rst)
    kick |=> !expire_o);
  // R9: a disabled watchdog never expires
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !expire_o);
  // R7: expiry is a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !expire_o);

endmodule

// File: rtl/brg_stretch.sv
module brg_stretch #(
  parameter int unsigned HOLD_CLKS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic lrst_n_o
);
  import brg_pkg::*;

  localparam int unsigned HW = brg_bits(HOLD_CLKS);
  localparam logic [HW-1:0] RELOAD = HW'(HOLD_CLKS - 1);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || trig_i) begin
      cnt_q    <= RELOAD;
      lrst_n_o <= 1'b0;
    end else begin
      lrst_n_o <= (cnt_q == '0);
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R6: any reason pulls the output low on the next edge
  a_r6_trig_low: assert property (@(posedge clk) disable iff (rst)
    trig_i |=> !lrst_n_o);
  // R6: release never follows a cycle with an active reason
  a_r6_clean_release: assert property (@(posedge clk) disable iff (rst)
    $rose(lrst_n_o) |-> !$past(trig_i));
  // R6: a pulse is never shorter than two clocks
  a_r6_min_width: assert property (@(posedge clk) disable iff (rst)
    $fell(lrst_n_o) |=> !lrst_n_o);

endmodule

// File: rtl/brg_local_reset.sv
module brg_local_reset #(
  parameter int unsigned CLK_HZ    = 125000000,
  parameter int unsigned WD_MS     = 2000,
  parameter int unsigned HOLD_CLKS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic sys_rst_n_i,
  input  logic button_i,
  input  logic bus_grant_n_i,
  input  logic sys_ctrl_i,
  input  logic sw_rst_wr_i,
  input  logic wd_en_i,
  input  logic wd_clr_i,
  output logic lrst_n_o,
  output logic sw_rst_o
);
  import brg_pkg::*;

  localparam int unsigned CLK_PER_MS = CLK_HZ / 1000;

  brg_src_t raw, src;
  logic     sw_q;
  logic     wd_exp;
  logic     trig;

  assign raw = '{sys: ~sys_rst_n_i, btn: button_i, gnt: ~bus_grant_n_i};

  brg_sync #(.WIDTH($bits(brg_src_t))) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw),
    .q_o (src)
  );

  brg_wdog #(.CLK_PER_MS(CLK_PER_MS), .WD_MS(WD_MS)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .en_i     (wd_en_i),
    .clr_i    (wd_clr_i),
    .expire_o (wd_exp)
  );

  // software reset bit: clearing while local reset is low beats a write
  always_ff @(posedge clk) begin
    if (rst || !lrst_n_o) sw_q <= 1'b0;
    else if (sw_rst_wr_i) sw_q <= 1'b1;
  end
  assign sw_rst_o = sw_q;

  assign trig = src.sys | src.btn | (sys_ctrl_i & src.gnt) | sw_q | wd_exp;

  brg_stretch #(.HOLD_CLKS(HOLD_CLKS)) u_stretch (
    .clk      (clk),
    .rst      (rst),
    .trig_i   (trig),
    .lrst_n_o (lrst_n_o)
  );

  // R1: power-on reset holds local reset low
  a_r1_por_low: assert property (@(posedge clk)
    rst |=> !lrst_n_o);
  // R5: the software bit is gone one edge after local reset is seen low
  a_r5_self_clear: assert property (@(posedge clk) disable iff (rst)
    !lrst_n_o |=> !sw_rst_o);
  // R2: a synchronised system reset pulls local reset low
  a_r2_sys_low: assert property (@(posedge clk) disable iff (rst)
    src.sys |=> !lrst_n_o);
  // R4: a grant-in counts only for a system controller
  a_r4_gnt_ctrl: assert property (@(posedge clk) disable iff (rst)
    (src.gnt && sys_ctrl_i) |=> !lrst_n_o);

endmodule

// File: tb/brg_local_reset_bench.sv
module brg_local_reset_bench;

  localparam int unsigned CLK_HZ = 4000;   // 4 clocks per ms
  localparam int unsigned WD_MS  = 5;
  localparam int unsigned HOLD   = 6;
  localparam int unsigned WP     = WD_MS * (CLK_HZ / 1000);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sys_rst_n = 1'b1, button = 1'b0, grant_n = 1'b1, sys_ctrl = 1'b0;
  logic sw_wr = 1'b0, wd_en = 1'b0, wd_clr = 1'b0;
  logic lrst_n, sw_rst;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  brg_local_reset #(.CLK_HZ(CLK_HZ), .WD_MS(WD_MS), .HOLD_CLKS(HOLD)) u_brg_local_reset (
    .clk           (clk),
    .rst           (rst),
    .sys_rst_n_i   (sys_rst_n),
    .button_i      (button),
    .bus_grant_n_i (grant_n),
    .sys_ctrl_i    (sys_ctrl),
    .sw_rst_wr_i   (sw_wr),
    .wd_en_i       (wd_en),
    .wd_clr_i      (wd_clr),
    .lrst_n_o      (lrst_n),
    .sw_rst_o      (sw_rst)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {sys reset active, button, grant active, system controller, expected lrst_n}
  localparam logic [4:0] VEC [8] = '{
    5'b0000_1,  // idle
    5'b1000_0,  // R2
    5'b0100_0,  // R3
    5'b0010_1,  // R4 grant ignored
    5'b0001_1,  // R4 strap alone
    5'b0011_0,  // R4 grant as controller
    5'b1111_0,  // all reasons
    5'b0110_0   // button beats ignored grant
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int lows;
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 lrst low in reset", lrst_n, 0);
    chk("R1 sw bit clear in reset", sw_rst, 0);
    rst = 1'b0;
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!lrst_n) lows++;
    end
    chk("R1 low clocks after release", lows, HOLD - 1);

    // table of asynchronous reasons: R2 R3 R4
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      sys_rst_n = ~VEC[v][4];
      button    = VEC[v][3];
      grant_n   = ~VEC[v][2];
      sys_ctrl  = VEC[v][1];
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2/R3/R4 vector %0d", v), lrst_n, VEC[v][0]);
      sys_rst_n = 1'b1; button = 1'b0; grant_n = 1'b1; sys_ctrl = 1'b0;
      repeat (HOLD + 4) @(negedge clk);
      chk($sformatf("R6 release after vector %0d", v), lrst_n, 1);
    end

    // R6 latency and exact width from a one-clock button pulse
    @(negedge clk);
    button = 1'b1;
    @(negedge clk);
    button = 1'b0;
    chk("R6 no change after one edge", lrst_n, 1);
    @(negedge clk);
    chk("R6 no change after two edges", lrst_n, 1);
    @(negedge clk);
    chk("R6 low on third edge", lrst_n, 0);
    lows = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!lrst_n) lows++;
    end
    chk("R6 pulse width", lows, HOLD);

    // R5 software reset bit
    @(negedge clk);
    sw_wr = 1'b1;
    @(negedge clk);
    sw_wr = 1'b0;
    chk("R5 bit set", sw_rst, 1);
    chk("R5 reset not yet", lrst_n, 1);
    @(negedge clk);
    chk("R5 reset asserted", lrst_n, 0);
    chk("R5 bit still set", sw_rst, 1);
    @(negedge clk);
    chk("R5 bit self cleared", sw_rst, 0);
    sw_wr = 1'b1;
    @(negedge clk);
    sw_wr = 1'b0;
    chk("R5 write during reset ignored", sw_rst, 0);
    repeat (HOLD + 4) @(negedge clk);
    chk("R5 reset released", lrst_n, 1);
    chk("R5 no repeat", sw_rst, 0);

    // R7 expiry with clear held high (R8 steady level)
    @(negedge clk);
    wd_en = 1'b1; wd_clr = 1'b1;
    @(posedge clk);                 // restart edge r
    repeat (WP) @(posedge clk);     // edge r+WP
    @(negedge clk);
    chk("R8 steady clear high, no reset yet", lrst_n, 1);
    @(negedge clk);
    chk("R7 expiry reset", lrst_n, 0);
    wd_en = 1'b0; wd_clr = 1'b0;
    repeat (HOLD + 4) @(negedge clk);
    chk("R7 release after expiry", lrst_n, 1);

    // R10 restart in the final tick clock
    @(negedge clk);
    wd_en = 1'b1; wd_clr = 1'b1;
    @(posedge clk);                 // restart edge r
    @(negedge clk);
    wd_clr = 1'b0;
    repeat (WP - 1) @(posedge clk); // edge r+WP-1
    @(negedge clk);
    wd_clr = 1'b1;                  // sampled on edge r+WP
    @(posedge clk);
    @(negedge clk);
    chk("R10 collision restart", lrst_n, 1);
    repeat (WP) @(posedge clk);
    @(negedge clk);
    chk("R10 full window after collision", lrst_n, 1);
    @(negedge clk);
    chk("R10 expiry one window later", lrst_n, 0);
    wd_en = 1'b0; wd_clr = 1'b0;
    repeat (HOLD + 4) @(negedge clk);

    // R8 regular servicing keeps the board running
    wd_en = 1'b1;
    lows = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      wd_clr = 1'b1;
      repeat (8) @(negedge clk);
      wd_clr = 1'b0;
      repeat (4) @(negedge clk);
      if (!lrst_n) lows++;
    end
    chk("R8 serviced watchdog never fires", lows, 0);

    // R9 disabled watchdog, then enabling starts a full window
    @(negedge clk);
    wd_en = 1'b0; wd_clr = 1'b0;
    lows = 0;
    for (int i = 0; i < 3 * WP; i++) begin
      @(negedge clk);
      if (!lrst_n) lows++;
    end
    chk("R9 disabled no reset", lows, 0);
    wd_en = 1'b1;
    repeat (WP) @(posedge clk);
    @(negedge clk);
    chk("R9 full window after enable", lrst_n, 1);
    @(negedge clk);
    chk("R9 expiry after enable", lrst_n, 0);
    repeat (HOLD + 4) @(negedge clk);

    // R8 restart on power-on release
    @(negedge clk);
    rst = 1'b1;
    wd_clr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 low during second reset", lrst_n, 0);
    rst = 1'b0;
    lows = 0;
    for (int i = 1; i < WP; i++) begin
      @(negedge clk);
      if (!lrst_n) lows++;
    end
    chk("R1 hold after second reset", lows, HOLD - 1);
    @(negedge clk);
    chk("R8 no expiry before window", lrst_n, 1);
    @(negedge clk);
    chk("R8 expiry counted from reset release", lrst_n, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule